// File: doc/BRIEF.md
# NAND Bank Select and Latch Decoder

This block sits between a host register/byte-write path and an external NAND bus shared by four banks. A control register carries, for every bank, an enable bit and an assert bit placed next to each other. A bank's active-low chip enable is driven low only while both of its bits are set. A host deselect request drops every assert bit at once and leaves the enable bits alone.

The host sends single bytes to a bank through the byte-write port. The two window bits of the byte's offset inside the bank window decide how the byte is latched: as a command (CLE), as an address (ALE) or as plain data. If both window bits are set, the byte would need CLE and ALE at the same time, which is illegal. Such a byte is refused and flagged. A byte aimed at a bank whose chip enable is not active is also refused and flagged. An accepted byte runs a fixed four-cycle bus sequence: one setup cycle, a two-clock write-enable pulse, and one hold cycle. The data bus and the latch lines stay still for the whole sequence.

Top module: `nbk_bank_ctl`

## Requirements
- R1: After reset the control register reads 0, all chip enables are high, `nand_we_n` is 1, CLE/ALE are 0 and both error flags are 0. Every bit of the control register reads back as last written.
- R2: `nand_ce_n[n]` is 0 only when control bit 2n (enable) and bit 2n+1 (assert) are both 1.
- R3: A `cfg_deselect` cycle clears control bits 1, 3, 5 and 7 (mask 0xAA) and keeps every other bit. When it coincides with a register write, the written value is stored with those bits cleared.
- R4: Writing 0 to the control register raises every chip enable.
- R5: A byte with offset bits [16:15] = 2'b10 is an address cycle. ALE is 1 and CLE is 0 for its whole sequence.
- R6: A byte with offset bits [16:15] = 2'b01 is a command cycle. CLE is 1 and ALE is 0 for its whole sequence.
- R7: A byte with offset bits [16:15] = 2'b00 is a data cycle. CLE and ALE both stay 0.
- R8: A byte with offset bits [16:15] = 2'b11 is refused. No strobe follows, neither CLE nor ALE rises, and the sticky `err_clash` flag is set. CLE and ALE are never 1 together.
- R9: A byte sent to a bank whose chip enable is high is refused without a strobe, and the sticky `err_unselected` flag is set. The flag stays set through later good writes until reset.
- R10: For an accepted byte, `bus_busy` is 1 for exactly 4 cycles: 1 setup cycle with `nand_we_n` high, then 2 cycles with `nand_we_n` low, then 1 hold cycle with `nand_we_n` high. `nand_dq`, CLE and ALE do not change during those cycles.
- R11: A byte offered while `bus_busy` is 1 is ignored. It causes no strobe and sets no flag, and the running sequence keeps its byte.
- R12: While `bus_busy` is 0, `nand_we_n` is 1, CLE and ALE are 0 and `nand_dq` is 0. During a sequence `nand_dq` shows the accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | REG_W (32) | Control register write value |
| cfg_deselect | input | 1 | Clear all assert bits |
| cfg_rdata | output | REG_W (32) | Control register contents |
| bw_valid | input | 1 | Byte write request |
| bw_bank | input | BANK_W (2) | Target bank |
| bw_offset | input | OFF_W (17) | Offset inside the bank window; bits 16 and 15 select the latch kind |
| bw_data | input | 8 | Byte to place on the bus |
| bus_busy | output | 1 | A bus sequence is running |
| nand_ce_n | output | NUM_BANKS (4) | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_dq | output | 8 | Output data bus |
| err_unselected | output | 1 | Sticky: byte sent to an inactive bank |
| err_clash | output | 1 | Sticky: byte asked for CLE and ALE together |

## Verification
The bench checks several enable/assert combinations: enable only, assert only, and a byte aimed at a neighbouring bank. A decoder that used only one of the two bits would strobe in one of these cases, and a wrong bank index would refuse a legal byte. The clash offset 0x18000 is tested to catch a design that gives one latch line priority, which would raise it and pulse the strobe. The bench offers a second byte in the middle of a sequence, so a design that accepted it would change the bus mid-pulse. It also checks deselect together with a register write, so a design that lets the write win would leave chip enables low.

// File: rtl/nbk_pkg.sv
package nbk_pkg;

    localparam int BYTE_W       = 8;
    localparam int ADDR_WIN_BIT = 16;
    localparam int CMD_WIN_BIT  = 15;

    typedef enum logic [1:0] {
        CYC_DATA  = 2'd0,
        CYC_CMD   = 2'd1,
        CYC_ADDR  = 2'd2,
        CYC_CLASH = 2'd3
    } cyc_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETUP  = 2'd1,
        SEQ_STROBE = 2'd2,
        SEQ_HOLD   = 2'd3
    } seq_state_e;

    typedef struct packed {
        cyc_kind_e          kind;
        logic [BYTE_W-1:0]  data;
    } xfer_t;

    function automatic cyc_kind_e classify(input logic addr_win, input logic cmd_win);
        case ({addr_win, cmd_win})
            2'b10:   return CYC_ADDR;
            2'b01:   return CYC_CMD;
            2'b11:   return CYC_CLASH;
            default: return CYC_DATA;
        endcase
    endfunction

endpackage

// File: rtl/nbk_ctrl_reg.sv
module nbk_ctrl_reg #(
    parameter int NUM_BANKS = 4,
    parameter int REG_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 deselect,
    output logic [REG_W-1:0]     rdata,
    output logic [NUM_BANKS-1:0] ce_n
);
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] ctrl_d;
    logic [REG_W-1:0] assert_mask;

    always_comb begin
        assert_mask = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            assert_mask[2*b+1] = 1'b1;
        end
    end

    always_comb begin
        ctrl_d = wr ? wdata : ctrl_q;
        if (deselect) begin
            ctrl_d = ctrl_d & ~assert_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign rdata = ctrl_q;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ce
        assign ce_n[g] = ~(ctrl_q[2*g] & ctrl_q[2*g+1]);
    end

endmodule

// File: rtl/nbk_cycle_decode.sv
module nbk_cycle_decode
    import nbk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int OFF_W     = 17,
    parameter int BANK_W    = 2
) (
    input  logic                 valid,
    input  logic                 busy,
    input  logic [BANK_W-1:0]    bank,
    input  logic [OFF_W-1:0]     offset,
    input  logic [BYTE_W-1:0]    data,
    input  logic [NUM_BANKS-1:0] ce_n,
    output logic                 start,
    output xfer_t                xfer,
    output logic                 clash,
    output logic                 unsel
);
    cyc_kind_e kind;
    logic      offered;
    logic      bank_on;

    assign kind    = classify(offset[ADDR_WIN_BIT], offset[CMD_WIN_BIT]);
    assign offered = valid && !busy;
    assign bank_on = !ce_n[bank];

    assign clash = offered && (kind == CYC_CLASH);
    assign unsel = offered && !bank_on;
    assign start = offered && bank_on && (kind != CYC_CLASH);

    assign xfer.kind = kind;
    assign xfer.data = data;

endmodule

// File: rtl/nbk_strobe_seq.sv
module nbk_strobe_seq
    import nbk_pkg::*;
#(
    parameter int WE_LOW_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_t             xfer_in,
    output logic              busy,
    output logic              we_n,
    output logic              cle,
    output logic              ale,
    output logic [BYTE_W-1:0] dq
);
    localparam int CNT_W = $clog2(WE_LOW_CLKS + 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    xfer_t            held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            held_q  <= '{kind: CYC_DATA, data: '0};
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        held_q  <= xfer_in;
                        state_q <= SEQ_SETUP;
                    end
                end
                SEQ_SETUP: begin
                    cnt_q   <= CNT_W'(WE_LOW_CLKS - 1);
                    state_q <= SEQ_STROBE;
                end
                SEQ_STROBE: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_HOLD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign busy = (state_q != SEQ_IDLE);
    assign we_n = (state_q != SEQ_STROBE);
    assign cle  = busy && (held_q.kind == CYC_CMD);
    assign ale  = busy && (held_q.kind == CYC_ADDR);
    assign dq   = busy ? held_q.data : '0;

endmodule

// File: rtl/nbk_bank_ctl.sv
module nbk_bank_ctl
    import nbk_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int REG_W       = 32,
    parameter int OFF_W       = 17,
    parameter int WE_LOW_CLKS = 2,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 cfg_deselect,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 bw_valid,
    input  logic [BANK_W-1:0]    bw_bank,
    input  logic [OFF_W-1:0]     bw_offset,
    input  logic [BYTE_W-1:0]    bw_data,
    output logic                 bus_busy,
    output logic [NUM_BANKS-1:0] nand_ce_n,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic [BYTE_W-1:0]    nand_dq,
    output logic                 err_unselected,
    output logic                 err_clash
);
    logic  start;
    logic  clash_hit;
    logic  unsel_hit;
    xfer_t xfer;

    nbk_ctrl_reg #(
        .NUM_BANKS (NUM_BANKS),
        .REG_W     (REG_W)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .deselect (cfg_deselect),
        .rdata    (cfg_rdata),
        .ce_n     (nand_ce_n)
    );

    nbk_cycle_decode #(
        .NUM_BANKS (NUM_BANKS),
        .OFF_W     (OFF_W),
        .BANK_W    (BANK_W)
    ) u_dec (
        .valid  (bw_valid),
        .busy   (bus_busy),
        .bank   (bw_bank),
        .offset (bw_offset),
        .data   (bw_data),
        .ce_n   (nand_ce_n),
        .start  (start),
        .xfer   (xfer),
        .clash  (clash_hit),
        .unsel  (unsel_hit)
    );

    nbk_strobe_seq #(
        .WE_LOW_CLKS (WE_LOW_CLKS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .xfer_in (xfer),
        .busy    (bus_busy),
        .we_n    (nand_we_n),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .dq      (nand_dq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_unselected <= 1'b0;
            err_clash      <= 1'b0;
        end else begin
            if (unsel_hit) err_unselected <= 1'b1;
            if (clash_hit) err_clash      <= 1'b1;
        end
    end

endmodule

// File: rtl/nbk_chk.sv
module nbk_chk #(
    parameter int NUM_BANKS   = 4,
    parameter int REG_W       = 32,
    parameter int OFF_W       = 17,
    parameter int WE_LOW_CLKS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_deselect,
    input logic [REG_W-1:0]     cfg_rdata,
    input logic                 bw_valid,
    input logic [OFF_W-1:0]     bw_offset,
    input logic                 bus_busy,
    input logic [NUM_BANKS-1:0] nand_ce_n,
    input logic                 nand_cle,
    input logic                 nand_ale,
    input logic                 nand_we_n,
    input logic [7:0]           nand_dq,
    input logic                 err_unselected,
    input logic                 err_clash
);
    logic [REG_W-1:0] amask;
    logic [7:0]       lo_cnt;

    always_comb begin
        amask = '0;
        for (int b = 0; b < NUM_BANKS; b++) amask[2*b+1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)             lo_cnt <= '0;
        else if (!nand_we_n) lo_cnt <= lo_cnt + 1'b1;
        else                 lo_cnt <= '0;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ce_chk
        // R2
        ce_map_chk: assert property (@(posedge clk) disable iff (rst)
            nand_ce_n[g] == !(cfg_rdata[2*g] && cfg_rdata[2*g+1]));
    end

    // R3
    deselect_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_deselect |=> ((cfg_rdata & amask) == '0));

    // R8
    latch_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    // R8
    clash_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (bw_valid && !bus_busy && bw_offset[16] && bw_offset[15]) |=> (!bus_busy && err_clash));

    // R9
    unsel_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_unselected |=> err_unselected);

    // R10
    we_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_we_n) |-> ($past(bus_busy) && bus_busy));

    // R10
    we_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> bus_busy);

    // R10
    we_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (int'(lo_cnt) == WE_LOW_CLKS));

    // R10
    bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_busy) && bus_busy) |-> ($stable(nand_dq) && $stable(nand_cle) && $stable(nand_ale)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_busy |-> (nand_we_n && !nand_cle && !nand_ale && (nand_dq == 8'h00)));

endmodule

bind nbk_bank_ctl nbk_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .REG_W       (REG_W),
    .OFF_W       (OFF_W),
    .WE_LOW_CLKS (WE_LOW_CLKS)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_deselect   (cfg_deselect),
    .cfg_rdata      (cfg_rdata),
    .bw_valid       (bw_valid),
    .bw_offset      (bw_offset),
    .bus_busy       (bus_busy),
    .nand_ce_n      (nand_ce_n),
    .nand_cle       (nand_cle),
    .nand_ale       (nand_ale),
    .nand_we_n      (nand_we_n),
    .nand_dq        (nand_dq),
    .err_unselected (err_unselected),
    .err_clash      (err_clash)
);

// File: tb/nbk_bank_ctl_tb.sv
module nbk_bank_ctl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_deselect = 1'b0;
    logic [31:0] cfg_rdata;
    logic        bw_valid = 1'b0;
    logic [1:0]  bw_bank = '0;
    logic [16:0] bw_offset = '0;
    logic [7:0]  bw_data = '0;
    logic        bus_busy;
    logic [3:0]  nand_ce_n;
    logic        nand_cle;
    logic        nand_ale;
    logic        nand_we_n;
    logic [7:0]  nand_dq;
    logic        err_unselected;
    logic        err_clash;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    nbk_bank_ctl u_dut (
        .clk            (clk),
        .rst            (rst),
        .cfg_wr         (cfg_wr),
        .cfg_wdata      (cfg_wdata),
        .cfg_deselect   (cfg_deselect),
        .cfg_rdata      (cfg_rdata),
        .bw_valid       (bw_valid),
        .bw_bank        (bw_bank),
        .bw_offset      (bw_offset),
        .bw_data        (bw_data),
        .bus_busy       (bus_busy),
        .nand_ce_n      (nand_ce_n),
        .nand_cle       (nand_cle),
        .nand_ale       (nand_ale),
        .nand_we_n      (nand_we_n),
        .nand_dq        (nand_dq),
        .err_unselected (err_unselected),
        .err_clash      (err_clash)
    );

    typedef struct packed {
        logic [31:0] ctrl;
        logic [1:0]  bank;
        logic [16:0] off;
        logic [7:0]  dat;
        logic        acc;
        logic        ecle;
        logic        eale;
        logic        eunsel;
        logic        eclash;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        {32'h0000_0003, 2'd0, 17'h10000, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 address
        {32'h0000_000C, 2'd1, 17'h08000, 8'h70, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R6 command
        {32'h0000_0030, 2'd2, 17'h00123, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R7 data
        {32'h0000_00C0, 2'd3, 17'h18000, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R8 clash
        {32'h0000_0010, 2'd2, 17'h00000, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R9 enable only
        {32'h0000_0020, 2'd2, 17'h00000, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R9 assert only
        {32'h0000_0003, 2'd1, 17'h08000, 8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R9 other bank
        {32'h0000_00FF, 2'd3, 17'h07FFF, 8'hE7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}   // R7 window bits clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cfg_wr = 1'b0; cfg_deselect = 1'b0; bw_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [31:0] v);
        cfg_wdata = v; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send(input logic [1:0] b, input logic [16:0] o, input logic [7:0] d);
        bw_bank = b; bw_offset = o; bw_data = d; bw_valid = 1'b1;
        @(negedge clk);
        bw_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 rdata", cfg_rdata, 32'h0);
        check("R1 ce_n", {28'h0, nand_ce_n}, 32'hF);
        check("R1 we_n/cle/ale", {29'h0, nand_we_n, nand_cle, nand_ale}, 32'h4);
        check("R1 flags", {30'h0, err_unselected, err_clash}, 32'h0);

        // Vector table walk
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            v = VECS[i];
            do_reset();
            cfg_write(v.ctrl);
            send(v.bank, v.off, v.dat);
            for (int p = 0; p < 5; p++) begin
                logic eb, ew;
                eb = v.acc && (p < 4);
                ew = !(v.acc && (p == 1 || p == 2));
                check($sformatf("R10 busy vec%0d p%0d", i, p), {31'h0, bus_busy}, {31'h0, eb});
                check($sformatf("R10 we_n vec%0d p%0d", i, p), {31'h0, nand_we_n}, {31'h0, ew});
                check($sformatf("R5/R6/R8 latch vec%0d p%0d", i, p), {30'h0, nand_cle, nand_ale},
                      {30'h0, v.ecle && eb, v.eale && eb});
                check($sformatf("R12 dq vec%0d p%0d", i, p), {24'h0, nand_dq}, {24'h0, eb ? v.dat : 8'h00});
                @(negedge clk);
            end
            check($sformatf("R9 unsel flag vec%0d", i), {31'h0, err_unselected}, {31'h0, v.eunsel});
            check($sformatf("R8 clash flag vec%0d", i), {31'h0, err_clash}, {31'h0, v.eclash});
        end

        // R1 readback, R2 ce mapping
        do_reset();
        cfg_write(32'hDEAD_BEEF);
        check("R1 readback", cfg_rdata, 32'hDEAD_BEEF);
        check("R2 ce_n map", {28'h0, nand_ce_n}, 32'h4);

        // R3 deselect keeps enables
        cfg_deselect = 1'b1;
        @(negedge clk);
        cfg_deselect = 1'b0;
        check("R3 deselect rdata", cfg_rdata, 32'hDEAD_BE45);
        check("R3 deselect ce_n", {28'h0, nand_ce_n}, 32'hF);

        // R3 deselect wins over simultaneous write
        cfg_deselect = 1'b1;
        cfg_write(32'h0000_00FF);
        cfg_deselect = 1'b0;
        check("R3 deselect+write rdata", cfg_rdata, 32'h55);
        check("R3 deselect+write ce_n", {28'h0, nand_ce_n}, 32'hF);

        // R4 writing zero deasserts all
        cfg_write(32'hFF);
        check("R2 all on", {28'h0, nand_ce_n}, 32'h0);
        cfg_write(32'h0);
        check("R4 zero ce_n", {28'h0, nand_ce_n}, 32'hF);
        check("R4 zero rdata", cfg_rdata, 32'h0);

        // R11 request during busy is ignored
        do_reset();
        cfg_write(32'h03);
        send(2'd0, 17'h08000, 8'h11);
        bw_bank = 2'd0; bw_offset = 17'h10000; bw_data = 8'h22; bw_valid = 1'b1;
        for (int p = 0; p < 4; p++) begin
            check($sformatf("R11 dq held p%0d", p), {24'h0, nand_dq}, 32'h11);
            check($sformatf("R11 cmd kept p%0d", p), {30'h0, nand_cle, nand_ale}, 32'h2);
            if (p == 3) bw_valid = 1'b0;
            @(negedge clk);
        end
        for (int p = 0; p < 3; p++) begin
            check($sformatf("R11 no second strobe p%0d", p), {30'h0, bus_busy, nand_we_n}, 32'h1);
            @(negedge clk);
        end
        check("R11 no flag", {30'h0, err_unselected, err_clash}, 32'h0);

        // R9 sticky flag survives a later good write
        do_reset();
        send(2'd1, 17'h0, 8'h44);
        check("R9 flag set", {31'h0, err_unselected}, 32'h1);
        cfg_write(32'h0C);
        send(2'd1, 17'h0, 8'h45);
        check("R9 good write accepted", {31'h0, bus_busy}, 32'h1);
        repeat (5) @(negedge clk);
        check("R9 flag sticky", {31'h0, err_unselected}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule